// File: doc/BRIEF.md
# SPI Master with Chip-Select Hold

This block is a memory-mapped SPI master. Each accepted write to the transmit register starts one frame. The frame length is fixed when the block is built, at 2 to 16 bits. The word goes out on `mosi` while `miso` is sampled on the opposite clock edge, so every frame is full duplex. The received word lands in a receive register once the frame ends. The serial clock only runs while a frame is in progress, so a read-only access still needs a dummy transmit write.

Chip-select lines are active low and selected one-hot. By default the selected line is released after every frame, so each frame gets its own select pulse. A hold bit in the control register keeps the selected line low between frames and while idle. Several short frames then form one longer transaction, for example three 8-bit frames for a device that needs 24 contiguous bits. Clock polarity, clock phase, bit order and the clock divider are build-time parameters.

Register map, by `addr`:
- 0: received word (read)
- 1: transmit word (write)
- 2: status (read; any write clears the overrun flag)
- 3: control (bit 10 is the hold bit)
- 4: slave select

Top module: `spi_hold_master`

## Requirements
- R1: After reset: status reads 0x5 (bit0 TRDY = 1, bit1 RRDY = 0, bit2 TMT = 1, bit3 ROE = 0), every `ss_n` line is high, `sclk` sits at CPOL, control reads 0 and select reads 1.
- R2: A write to address 1 while TRDY = 1 sends the low FRAME_W bits on `mosi`, MSB first in the default build. The frame has exactly FRAME_W `sclk` pulses. With CPOL = 0 and CPHA = 0, `mosi` is valid at each rising `sclk` edge.
- R3: `miso` is sampled on the edges opposite to launch, MSB first. After the frame, the word reads at address 0 and RRDY (status bit1) is 1.
- R4: A read of address 0 clears RRDY unless a frame completes in that same cycle.
- R5: If a frame completes while RRDY = 1 and no read of address 0 happens in that cycle, ROE (status bit3) becomes 1 and address 0 holds the newer word. If the read coincides with completion, the read returns the older word, RRDY stays 1 and ROE stays 0. Any write to address 2 clears ROE.
- R6: A transmit write accepted during a frame waits and is sent after that frame. A transmit write while TRDY = 0 is ignored and never transmitted.
- R7: With the hold bit clear, the selected `ss_n` line rises after every frame, so N frames produce N separate low pulses.
- R8: With control bit 10 set, the selected `ss_n` line is low while idle and stays low across consecutive frames, giving a single low pulse.
- R9: Clearing the hold bit while idle raises `ss_n` within one clock. Clearing it during a frame leaves `ss_n` low until that frame ends.
- R10: At most one `ss_n` line is low at a time, and only the line whose select bit is set. A select write with more than one bit set is ignored. Select 0 drives no line low.
- R11: `sclk` stays at CPOL whenever no frame is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; marks a consuming read of address 0 |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
Two events can land in the same system clock: frame completion, which loads the receive register and sets RRDY, and a software read of address 0, which clears RRDY. The bench provokes this by leaving one word unread and starting a second frame. It then times a read to fall exactly on the completion cycle, which is 2·FRAME_W+1 divider periods after the frame starts. The result is judged correct when three things hold: the read returns the older word, the status then shows RRDY = 1 with no overrun, and the next read returns the newer word. A separate run with no read at completion must raise the overrun flag.

// File: rtl/spi_hold_master.sv
module spi_hold_master #(
  parameter int FRAME_W   = 8,
  parameter int NUM_SS    = 2,
  parameter int HALF_DIV  = 2,
  parameter bit CPOL      = 1'b0,
  parameter bit CPHA      = 1'b0,
  parameter bit LSB_FIRST = 1'b0,
  parameter int BUS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n
);
  localparam int EW = $clog2(2*FRAME_W + 1);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*FRAME_W);
  localparam logic [DW-1:0] DIV_TOP   = DW'(HALF_DIV - 1);
  localparam int HOLD_BIT = 10;

  logic [FRAME_W-1:0] tx_buf, tx_sh, rx_sh, rx_reg;
  logic [EW-1:0]      edge_cnt;
  logic [DW-1:0]      div_cnt;
  logic [NUM_SS-1:0]  sel;
  logic tx_full, busy, rrdy, roe, hold, sclk_q;

  wire tick   = busy && (div_cnt == DIV_TOP);
  wire fin    = tick && (edge_cnt == LAST_EDGE);
  wire start  = !busy && tx_full;
  wire wr_tx  = wr_en && (addr == 3'd1) && !tx_full;
  wire rd_rx  = rd_en && (addr == 3'd0);
  wire sample = tick && !fin && (edge_cnt[0] == CPHA);
  wire shift  = tick && !fin && (edge_cnt[0] != CPHA) && (edge_cnt != '0);
  wire sel_ok = $countones(wdata[NUM_SS-1:0]) <= 1;
  wire unused_wbits = ^wdata;

  assign sclk = sclk_q;
  assign mosi = LSB_FIRST ? tx_sh[0] : tx_sh[FRAME_W-1];
  assign ss_n = ~(sel & {NUM_SS{busy | hold}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0; tx_sh <= '0; rx_sh <= '0; rx_reg <= '0;
      edge_cnt <= '0; div_cnt <= '0;
      sel <= NUM_SS'(1);
      tx_full <= 1'b0; busy <= 1'b0; rrdy <= 1'b0; roe <= 1'b0;
      hold <= 1'b0; sclk_q <= CPOL;
    end else begin
      if (wr_tx) begin
        tx_buf  <= wdata[FRAME_W-1:0];
        tx_full <= 1'b1;
      end else if (start) begin
        tx_full <= 1'b0;
      end

      if (start) begin
        busy     <= 1'b1;
        div_cnt  <= '0;
        edge_cnt <= '0;
        tx_sh    <= tx_buf;
      end else if (busy) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (fin) busy <= 1'b0;
          else begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        if (sample)
          rx_sh <= LSB_FIRST ? {miso, rx_sh[FRAME_W-1:1]} : {rx_sh[FRAME_W-2:0], miso};
        if (shift)
          tx_sh <= LSB_FIRST ? (tx_sh >> 1) : (tx_sh << 1);
      end

      if (fin) rx_reg <= rx_sh;
      rrdy <= fin | (rrdy & ~rd_rx);

      if (wr_en && addr == 3'd2) roe <= 1'b0;
      else if (fin && rrdy && !rd_rx) roe <= 1'b1;

      if (wr_en && addr == 3'd3) hold <= wdata[HOLD_BIT];
      if (wr_en && addr == 3'd4 && sel_ok) sel <= wdata[NUM_SS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[FRAME_W-1:0] = rx_reg;
      3'd2: rdata[3:0] = {roe, ~busy & ~tx_full, rrdy, ~tx_full};
      3'd3: rdata[HOLD_BIT] = hold;
      3'd4: rdata[NUM_SS-1:0] = sel;
      default: rdata = '0;
    endcase
  end
endmodule

module spi_hold_master_chk #(
  parameter int NUM_SS = 2,
  parameter bit CPOL   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SS-1:0] ss_n,
  input logic              sclk,
  input logic              busy,
  input logic              hold,
  input logic              rrdy,
  input logic              roe,
  input logic              fin,
  input logic              rd_rx
);
  // R10
  one_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_n) <= 1);

  // R11
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == CPOL);

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(roe) |-> $past(rrdy) && $past(fin) && !$past(rd_rx));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !fin |=> !rrdy);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !hold |-> &ss_n);
endmodule

bind spi_hold_master spi_hold_master_chk #(.NUM_SS(NUM_SS), .CPOL(CPOL)) i_chk (.*);

// File: tb/test_spi_hold_master.sv
module test_spi_hold_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = 16'd0, rdata;
  logic        sclk, mosi, miso;
  logic [1:0]  ss_n;

  int tests = 0, fails = 0;
  int rises = 0, falls0 = 0;
  logic [7:0]  slv_word = 8'h00;
  logic [2:0]  pos = 3'd0;
  logic [23:0] cap = 24'd0;

  always #4 clk = ~clk;

  spi_hold_master i_spi_hold_master (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n));

  assign miso = slv_word[3'd7 - pos];

  always @(posedge sclk) begin
    cap = {cap[22:0], mosi};
    rises = rises + 1;
    #1;
    pos = pos + 3'd1;
  end

  always @(negedge ss_n[0]) falls0 = falls0 + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_tmt;
    logic [15:0] s;
    for (int i = 0; i < 400; i++) begin
      peek(3'd2, s);
      if (s[2]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int r0, f0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(3'd2, d); chk(d == 16'h5, "R1 status", d, 5);
    chk(ss_n == 2'b11, "R1 ss_n", ss_n, 3);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    peek(3'd3, d); chk(d == 16'h0, "R1 control", d, 0);
    peek(3'd4, d); chk(d == 16'h1, "R1 select", d, 1);

    // R2 R3 R4 R7 sweep over every transmit word
    for (int v = 0; v < 256; v++) begin
      logic [7:0] exp_rx;
      exp_rx = 8'(v * 37 + 11);
      slv_word = exp_rx;
      r0 = rises; f0 = falls0;
      wr(3'd1, 16'(v));
      wait_tmt;
      chk(cap[7:0] == 8'(v), "R2 mosi word", cap[7:0], v);
      chk(rises - r0 == 8, "R2 pulse count", rises - r0, 8);
      chk(falls0 - f0 == 1 && ss_n == 2'b11, "R7 one pulse per frame", falls0 - f0, 1);
      peek(3'd2, d); chk(d[1] == 1'b1, "R3 rrdy set", d[1], 1);
      rd(3'd0, d); chk(d == 16'(exp_rx), "R3 rx word", d, exp_rx);
      peek(3'd2, d); chk(d[1] == 1'b0, "R4 rrdy cleared", d[1], 0);
    end

    // R11 idle clock
    r0 = rises;
    repeat (50) @(posedge clk);
    chk(rises == r0 && sclk == 1'b0, "R11 idle sclk", rises - r0, 0);

    // R5 overrun
    slv_word = 8'h3C; wr(3'd1, 16'h11); wait_tmt;
    slv_word = 8'hC3; wr(3'd1, 16'h22); wait_tmt;
    peek(3'd2, d); chk(d == 16'hF, "R5 roe set", d, 16'hF);
    rd(3'd0, d); chk(d == 16'hC3, "R5 newer word kept", d, 16'hC3);
    wr(3'd2, 16'h0);
    peek(3'd2, d); chk(d == 16'h5, "R5 roe cleared", d, 5);

    // R5 read coinciding with frame completion
    slv_word = 8'h5A; wr(3'd1, 16'h01); wait_tmt;
    slv_word = 8'h96; wr(3'd1, 16'h02);
    repeat (34) @(posedge clk);
    rd(3'd0, d); chk(d == 16'h5A, "R5 coincident read old", d, 16'h5A);
    peek(3'd2, d); chk(d == 16'h7, "R5 coincident status", d, 7);
    rd(3'd0, d); chk(d == 16'h96, "R5 coincident new word", d, 16'h96);

    // R6 queued and ignored writes
    slv_word = 8'h77;
    r0 = rises; f0 = falls0;
    wr(3'd1, 16'hA1);
    wr(3'd1, 16'hB2);
    wr(3'd1, 16'hC3);
    peek(3'd2, d); chk(d[0] == 1'b0, "R6 trdy low while queued", d[0], 0);
    wait_tmt;
    chk(rises - r0 == 16, "R6 third write ignored", rises - r0, 16);
    chk(cap[15:0] == 16'hA1B2, "R6 queued order", cap[15:0], 16'hA1B2);
    chk(falls0 - f0 == 2, "R7 two pulses", falls0 - f0, 2);
    rd(3'd0, d); wr(3'd2, 16'h0);

    // R8 hold across three frames
    f0 = falls0;
    wr(3'd3, 16'h0400);
    chk(ss_n == 2'b10, "R8 low while idle", ss_n, 2);
    begin
      logic [23:0] rx24, tx24;
      tx24 = 24'h123456; rx24 = 24'h0;
      for (int k = 0; k < 3; k++) begin
        slv_word = 8'(24'hABCDEF >> (16 - 8*k));
        wr(3'd1, 16'(8'(tx24 >> (16 - 8*k))));
        wait_tmt;
        chk(ss_n[0] == 1'b0, "R8 held between frames", ss_n[0], 0);
        rd(3'd0, d);
        rx24 = {rx24[15:0], d[7:0]};
      end
      chk(rx24 == 24'hABCDEF, "R8 24-bit receive", rx24, 24'hABCDEF);
      chk(cap == tx24, "R8 24-bit transmit", cap, tx24);
    end
    chk(falls0 - f0 == 1, "R8 single pulse", falls0 - f0, 1);

    // R9 clear while idle
    wr(3'd3, 16'h0);
    chk(ss_n == 2'b11, "R9 idle release", ss_n, 3);

    // R9 clear mid-frame
    f0 = falls0;
    wr(3'd3, 16'h0400);
    wr(3'd1, 16'h55);
    repeat (6) @(posedge clk);
    wr(3'd3, 16'h0);
    chk(ss_n[0] == 1'b0, "R9 held until frame end", ss_n[0], 0);
    wait_tmt;
    chk(ss_n == 2'b11, "R9 released after frame", ss_n, 3);
    chk(falls0 - f0 == 1, "R9 single pulse", falls0 - f0, 1);
    rd(3'd0, d);

    // R10 select
    wr(3'd4, 16'h2);
    peek(3'd4, d); chk(d == 16'h2, "R10 select write", d, 2);
    wr(3'd1, 16'h3F);
    repeat (10) @(posedge clk);
    @(negedge clk); chk(ss_n == 2'b01, "R10 only line 1", ss_n, 1);
    wait_tmt; rd(3'd0, d);
    wr(3'd4, 16'h3);
    peek(3'd4, d); chk(d == 16'h2, "R10 multi-bit ignored", d, 2);
    wr(3'd4, 16'h0);
    wr(3'd1, 16'h0F);
    repeat (10) @(posedge clk);
    @(negedge clk); chk(ss_n == 2'b11, "R10 none selected", ss_n, 3);
    wait_tmt; rd(3'd0, d);
    wr(3'd4, 16'h1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule